// File: doc/BRIEF.md
# Register-Programmed Serial Peripheral Interface Master

This block is a single-buffered SPI master that sits on a small 16-bit register bus. Software configures the controller through a control word, then writes one data word. That write launches a serial exchange: the word leaves on MOSI, most significant bit first, while MISO is captured into the same number of bits. The exchange runs at a bit rate derived from the core clock by a programmable divider. When the last bit is in, the captured word is held for software and a receive-full flag is raised. Reading the data register returns the held word and drops the flag.

The word length is either 8 or 16 bits. The clock idle level and the sampling edge follow the four usual SPI clocking modes. A single level interrupt combines a "word received" condition and a "ready for the next word" condition, each with its own enable. Chip selects are left to the surrounding system.

Top module: `spi_host_ctrl`

## Requirements
- R1: Registers decode on the byte address `busAddr`: data at 0x0, control at 0x2, status at 0x4. Reads are combinational. Control reads back the last written value. Status reads `{14'b0, full, busy}` (bit 1 full, bit 0 busy). Reading data returns the held received word.
- R2: Control bit 0 is the enable. A data write with enable set and busy clear starts an exchange and sets busy on the next clock. A data write with enable clear is dropped. Clearing enable during an exchange aborts it: busy drops, SCLK returns to its idle level and the full flag is left unchanged.
- R3: A data write while busy is dropped. The exchange in progress keeps its length and its MOSI bit stream.
- R4: Control bit 2 picks the word length: 0 gives 8 bits, 1 gives 16 bits. Bits go out and come in MSB first. In 8-bit mode the transmitted bits are bits 7..0 of the written word, and the held word reads with bits 15..8 zero.
- R5: Control bits 15:9 hold the divider D. Every SCLK half period lasts D+1 core clocks. The first SCLK edge comes D+1 clocks after the starting write. Busy stays high for exactly 2·N·(D+1) clocks for an N-bit word.
- R6: Control bit 7 is the polarity: SCLK idles at its value whenever busy is clear. Control bit 8 is the phase. With phase 0, MISO is sampled on the first edge of each bit and the MSB is on MOSI before the first edge. With phase 1, MISO is sampled on the second edge of each bit. MOSI changes only on non-sampling edges.
- R7: The full flag (status bit 1) rises when an exchange completes and is cleared by a data read. A completion while full is still set replaces the held word with the new one.
- R8: `irq` equals enable AND ((control bit 5 AND full) OR (control bit 6 AND NOT busy)).
- R9: After reset, the control and status registers read zero, and `sclk`, `mosi` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe, one cycle per write |
| busRdEn | input | 1 | Register read strobe; a data read clears full |
| busAddr | input | 3 | Byte address of the register |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data of the addressed register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume software leaves the word length, divider, polarity and phase fields unchanged while busy is high. Only the enable bit may be cleared mid-exchange. Under that assumption, the edge-count check is allowed to trust the length field at the end of an exchange, and the idle-level check is allowed to trust the polarity bit. The bench writes control only while the status register shows idle, apart from the one deliberate abort, and that abort changes nothing but the enable bit. Its slave model presents MISO only on non-sampling edges, so every captured bit is settled at least one core clock before it is sampled.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  // control word field positions (software decodes these)
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned WIDE_BIT  = 2;
  localparam int unsigned IE_RX_BIT = 5;
  localparam int unsigned IE_TX_BIT = 6;
  localparam int unsigned CPOL_BIT  = 7;
  localparam int unsigned CPHA_BIT  = 8;
  localparam int unsigned DIV_LSB   = 9;

  // byte offsets of the registers
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_CTRL = 2;
  localparam int unsigned OFS_STAT = 4;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;
    logic sample;
    logic drive;
    logic finish;
    logic clearFull;
    logic wide;
    logic phase;
  } xferStrobe_t;
endpackage

// File: rtl/spi_host_ctl.sv
module spi_host_ctl
  import spi_host_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              dataWr,
  input  logic              dataRd,
  input  logic [WORD_W-1:0] wrVal,
  output logic [WORD_W-1:0] ctrlQ,
  output logic              busy,
  output logic              sclk,
  output xferStrobe_t       stb
);
  localparam int unsigned EDGE_W = $clog2(2 * WORD_W + 1);
  localparam int unsigned HALF   = WORD_W / 2;

  logic [DIV_W-1:0]  divVal;
  logic [DIV_W-1:0]  halfCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] edgeNum;
  logic [EDGE_W-1:0] edgeTotal;
  logic              sclkPhase;
  logic              en, wide, cpol, cpha;
  logic              edgeNow, oddEdge, startGo, lastEdge;

  assign divVal    = ctrlQ[DIV_LSB +: DIV_W];
  assign en        = ctrlQ[EN_BIT];
  assign wide      = ctrlQ[WIDE_BIT];
  assign cpol      = ctrlQ[CPOL_BIT];
  assign cpha      = ctrlQ[CPHA_BIT];

  assign edgeNow   = busy && en && (halfCnt == divVal);
  assign edgeNum   = edgeCnt + 1'b1;
  assign oddEdge   = edgeNum[0];
  assign edgeTotal = wide ? EDGE_W'(2 * WORD_W) : EDGE_W'(2 * HALF);
  assign lastEdge  = edgeNow && (edgeNum == edgeTotal);
  assign startGo   = dataWr && en && !busy;
  assign sclk      = cpol ^ sclkPhase;

  always_comb begin
    stb           = '0;
    stb.load      = startGo;
    stb.sample    = edgeNow && (cpha ? !oddEdge : oddEdge);
    // phase 1 already presents the MSB, so its first edge does not shift
    stb.drive     = edgeNow && (cpha ? (oddEdge && edgeNum != EDGE_W'(1)) : !oddEdge);
    stb.finish    = lastEdge;
    stb.clearFull = dataRd;
    stb.wide      = wide;
    stb.phase     = cpha;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ <= wrVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      halfCnt   <= '0;
      edgeCnt   <= '0;
      sclkPhase <= 1'b0;
    end else if (startGo) begin
      busy      <= 1'b1;
      halfCnt   <= '0;
      edgeCnt   <= '0;
      sclkPhase <= 1'b0;
    end else if (busy && !en) begin
      busy      <= 1'b0;
      sclkPhase <= 1'b0;
    end else if (edgeNow) begin
      halfCnt   <= '0;
      edgeCnt   <= edgeNum;
      sclkPhase <= ~sclkPhase;
      if (lastEdge) busy <= 1'b0;
    end else if (busy) begin
      halfCnt <= halfCnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_host_dp.sv
module spi_host_dp
  import spi_host_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       stb,
  input  logic [WORD_W-1:0] wrVal,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] holdQ,
  output logic              fullQ
);
  localparam int unsigned HALF = WORD_W / 2;

  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic [WORD_W-1:0] rxNext;

  assign mosi   = txShift[WORD_W-1];
  assign rxNext = {rxShift[WORD_W-2:0], miso};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else if (stb.load) begin
      txShift <= stb.wide ? wrVal : {wrVal[HALF-1:0], {HALF{1'b0}}};
      rxShift <= '0;
    end else begin
      if (stb.drive)  txShift <= {txShift[WORD_W-2:0], 1'b0};
      if (stb.sample) rxShift <= rxNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= '0;
      fullQ <= 1'b0;
    end else if (stb.finish) begin
      // with phase 1 the final edge is itself a sampling edge
      holdQ <= stb.phase ? rxNext : rxShift;
      fullQ <= 1'b1;
    end else if (stb.clearFull) begin
      fullQ <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  logic              selData, selCtrl, selStat;
  logic [WORD_W-1:0] ctrlQ, holdQ, statQ;
  logic              busy, fullQ;
  xferStrobe_t       stb;

  assign selData = busAddr == ADDR_W'(OFS_DATA);
  assign selCtrl = busAddr == ADDR_W'(OFS_CTRL);
  assign selStat = busAddr == ADDR_W'(OFS_STAT);

  spi_host_ctl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) ctl_i (
    .clk(clk), .rstN(rstN),
    .ctrlWr(busWrEn && selCtrl),
    .dataWr(busWrEn && selData),
    .dataRd(busRdEn && selData),
    .wrVal(busWrData),
    .ctrlQ(ctrlQ), .busy(busy), .sclk(sclk), .stb(stb)
  );

  spi_host_dp #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrVal(busWrData),
    .miso(miso), .mosi(mosi), .holdQ(holdQ), .fullQ(fullQ)
  );

  assign statQ = {{(WORD_W-2){1'b0}}, fullQ, busy};

  always_comb begin
    if (selData)      busRdData = holdQ;
    else if (selCtrl) busRdData = ctrlQ;
    else if (selStat) busRdData = statQ;
    else              busRdData = '0;
  end

  assign irq = ctrlQ[EN_BIT] &
               ((ctrlQ[IE_RX_BIT] & fullQ) | (ctrlQ[IE_TX_BIT] & ~busy));
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk
  import spi_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [WORD_W-1:0] ctrlQ,
  input logic              busy,
  input logic              fullQ,
  input logic              sclk,
  input logic              irq
);
  logic       dataAcc, en, sclkPrev, sclkChg;
  logic [7:0] toggleCnt;

  assign dataAcc = busAddr == ADDR_W'(OFS_DATA);
  assign en      = ctrlQ[EN_BIT];
  assign sclkChg = sclk != sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      toggleCnt <= '0;
    end else begin
      sclkPrev <= sclk;
      if (!busy)        toggleCnt <= '0;
      else if (sclkChg) toggleCnt <= toggleCnt + 1'b1;
    end
  end

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && dataAcc && en && !busy |=> busy);

  a_r2_disabled_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    !en && !busy |=> !busy);

  a_r5_edge_total: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) && en |->
      (int'(toggleCnt) + int'(sclkChg)) == (ctrlQ[WIDE_BIT] ? 4 * (WORD_W / 2) : WORD_W));

  a_r6_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sclk == ctrlQ[CPOL_BIT]);

  a_r7_full_on_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) && en |-> fullQ);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && dataAcc && !busy |=> !fullQ);

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    !en |-> !irq);

  a_r8_irq_on_full: assert property (@(posedge clk) disable iff (!rstN)
    en && ctrlQ[IE_RX_BIT] && fullQ |-> irq);

  a_r8_quiet_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy && !fullQ |-> !irq);
endmodule

bind spi_host_ctrl spi_host_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) chk_i (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddr(busAddr), .ctrlQ(ctrlQ), .busy(busy), .fullQ(fullQ),
  .sclk(sclk), .irq(irq)
);

// File: tb/spi_host_ctrl_tb_top.sv
module spi_host_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        sclk, mosi, irq;
  logic        miso = 1'b0;

  int checks = 0;
  int errors = 0;

  // slave model state
  bit          slaveOn = 1'b0;
  bit          sCpol, sCpha;
  int          sPtr;
  logic [15:0] sWord, capMosi;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_host_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
  );

  always @(sclk) begin
    if (slaveOn) begin
      if ((sclk != sCpol) ^ sCpha) capMosi = {capMosi[14:0], mosi};
      else if (sPtr >= 0) begin
        miso = sWord[sPtr];
        sPtr--;
      end
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  function automatic logic [15:0] ctrlWord(int mode, bit wide, int div, bit ieRx, bit ieTx, bit en);
    return 16'((div << 9) | (mode[0] << 8) | (mode[1] << 7) | (ieTx << 6) |
               (ieRx << 5) | (wide << 2) | en);
  endfunction

  task automatic runXfer(int mode, bit wide, int div, logic [15:0] tx, logic [15:0] rx,
                         bit intrude, bit doRead);
    int n = wide ? 16 : 8;
    int cyc = 0;
    logic [15:0] mask = wide ? 16'hFFFF : 16'h00FF;
    logic [15:0] v;
    busWrite(3'd2, ctrlWord(mode, wide, div, 1'b1, 1'b0, 1'b1));
    check("R6 idle level before start", 16'(sclk), 16'(mode[1]));
    sCpol = mode[1]; sCpha = mode[0]; sWord = rx; capMosi = '0;
    if (!sCpha) begin miso = rx[n-1]; sPtr = n - 2; end
    else sPtr = n - 1;
    slaveOn = 1'b1;
    busWrite(3'd0, tx);
    busAddr = 3'd4; busRdEn = 1'b1;
    while (1) begin
      if (intrude && cyc == 2) begin
        busRdEn = 1'b0; busAddr = 3'd0; busWrEn = 1'b1; busWrData = ~tx;
        cyc++;
        @(negedge clk);
        busWrEn = 1'b0; busAddr = 3'd4; busRdEn = 1'b1;
        continue;
      end
      #1;
      if (!busRdData[0] || cyc > 5000) break;
      cyc++;
      @(negedge clk);
    end
    busRdEn = 1'b0;
    slaveOn = 1'b0;
    check("R5 busy length", 16'(cyc), 16'(2 * n * (div + 1)));
    check(intrude ? "R3 mosi stream kept" : "R4 R6 mosi bits", capMosi & mask, tx & mask);
    check("R6 idle level after", 16'(sclk), 16'(mode[1]));
    busRead(3'd4, v);
    check("R7 status full", v, 16'h0002);
    check("R8 irq on full", 16'(irq), 16'h0001);
    if (doRead) begin
      busRead(3'd0, v);
      check("R1 R4 received word", v, rx & mask);
      busRead(3'd4, v);
      check("R7 full cleared", v, 16'h0000);
      check("R8 irq drops", 16'(irq), 16'h0000);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int k = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9 reset state
    busRead(3'd2, v); check("R9 control reset", v, 16'h0000);
    busRead(3'd4, v); check("R9 status reset", v, 16'h0000);
    check("R9 sclk reset", 16'(sclk), 16'h0000);
    check("R9 mosi reset", 16'(mosi), 16'h0000);
    check("R9 irq reset", 16'(irq), 16'h0000);

    // sweep: mode x size x divider
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 2; w++) begin
        foreach (v[i]) begin end
        for (int di = 0; di < 3; di++) begin
          int dv = (di == 0) ? 0 : (di == 1) ? 2 : 5;
          logic [15:0] tx = 16'hA5C3 ^ 16'(k * 16'h1357);
          logic [15:0] rx = 16'h3C96 + 16'(k * 16'h02F1);
          runXfer(m, w[0], dv, tx, rx, 1'b0, 1'b1);
          k++;
        end
      end
    end

    // R1 control readback
    busWrite(3'd2, ctrlWord(2, 1'b1, 37, 1'b1, 1'b1, 1'b0));
    busRead(3'd2, v);
    check("R1 control readback", v, ctrlWord(2, 1'b1, 37, 1'b1, 1'b1, 1'b0));

    // R2 data write while disabled is dropped
    busWrite(3'd0, 16'h1234);
    busRead(3'd4, v);
    check("R2 disabled write ignored", v, 16'h0000);

    // R8 interrupt gating by enable and ready enable
    busWrite(3'd2, ctrlWord(0, 1'b1, 0, 1'b0, 1'b1, 1'b1));
    #1 check("R8 irq ready when idle", 16'(irq), 16'h0001);
    busWrite(3'd2, ctrlWord(0, 1'b1, 0, 1'b0, 1'b1, 1'b0));
    #1 check("R8 irq gated by enable", 16'(irq), 16'h0000);

    // R2 abort by clearing enable mid-exchange
    busWrite(3'd2, ctrlWord(2, 1'b1, 5, 1'b1, 1'b0, 1'b1));
    busWrite(3'd0, 16'hBEEF);
    repeat (20) @(negedge clk);
    busWrite(3'd2, ctrlWord(2, 1'b1, 5, 1'b1, 1'b0, 1'b0));
    busRead(3'd4, v);
    check("R2 abort clears busy keeps full", v, 16'h0000);
    check("R2 abort idle level", 16'(sclk), 16'h0001);

    // R3 write during exchange dropped
    runXfer(1, 1'b1, 1, 16'h5A3C, 16'hC3A5, 1'b1, 1'b1);

    // R7 overwrite while full
    runXfer(0, 1'b1, 0, 16'h0F0F, 16'h1111, 1'b0, 1'b0);
    runXfer(3, 1'b0, 1, 16'hFF81, 16'h22E7, 1'b0, 1'b0);
    busRead(3'd0, v);
    check("R7 overwrite keeps newest", v, 16'h00E7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule